// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Waveform Generator

This block is a 16-bit counter with two compare channels. A 4-bit mode input selects how it counts: a single ramp that wraps, or a ramp that climbs to a ceiling and then falls back to zero. The same mode input also picks the ceiling (TOP), the moment at which buffered compare values become active, and the count event that raises the overflow flag. The counter advances only on cycles where the `tick` input is high. A prescaler or clock-source selector outside the block generates that tick.

Each channel has a shadow register and an active register. Depending on the mode, a write lands in the active register at once, or waits in the shadow register until the next TOP or zero event. The block produces a one-cycle match strobe for each channel and one waveform output for each channel. The overflow flag stays set until software clears it with a strobe.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset, `count` is 0, both match strobes are 0, both waveform outputs are 0 and `ovf_flag` is 0.
- R2: In modes 0, 4, 12, 5, 6, 7, 14 and 15 (single ramp), a tick at count equal to TOP loads 0, and any other tick adds 1, wrapping at 0xFFFF. On a cycle without a tick, `count` keeps its value.
- R3: The `mode` value selects TOP. Modes 1 and 5 use 0x00FF. Modes 2 and 6 use 0x01FF. Modes 3 and 7 use 0x03FF. Mode 0 uses 0xFFFF. Modes 4, 9, 11 and 15 use the active channel-A compare value. Modes 8, 10, 12 and 14 use the `cap_val` input.
- R4: Modes 1, 2, 3, 8, 9, 10 and 11 count up and down. Rising, a tick at a count at or above TOP turns the count downward and subtracts 1 (at 0 it stays at 0). Falling, a tick at 0 turns the count upward and loads 1 (0 if TOP is 0). No turning value is repeated.
- R5: A compare write goes straight to the active register in modes 0, 4 and 12. In modes 8 and 9 it is copied from the shadow register on a tick at count 0. In all other counting modes it is copied on a tick at count equal to TOP. If a write and a copy happen on the same edge, the old shadow value is copied.
- R6: A channel's match strobe is high for the one cycle that follows a tick at which `count` equals that channel's active compare value.
- R7: In modes 5, 6, 7, 14 and 15, a tick at count equal to TOP sets the channel output to 1. Otherwise, a tick at a compare match clears it to 0.
- R8: In modes 1, 2, 3, 8, 9, 10 and 11, a tick at a compare match clears the output while the count is rising and sets it while the count is falling.
- R9: The overflow event is a tick at count 0xFFFF in modes 0, 4 and 12. It is a tick at count equal to TOP in modes 5, 6, 7, 14 and 15. It is a tick at count 0 in all other counting modes.
- R10: `ovf_flag` is set by an overflow event and cleared by `ovf_clr`. It holds its value otherwise. When an event and a clear occur on the same edge, the flag ends up set.
- R11: Mode 13 is idle. Ticks are ignored, `count` holds, match strobes stay 0, outputs are 0, no overflow event occurs and no buffered compare value is copied.
- R12: In modes 0, 4 and 12, both waveform outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for one cycle |
| mode | input | 4 | Mode select (0 to 15) |
| cmpa_wr | input | 1 | Write strobe for the channel-A compare value |
| cmpa_wdata | input | 16 | Channel-A compare write data |
| cmpb_wr | input | 1 | Write strobe for the channel-B compare value |
| cmpb_wdata | input | 16 | Channel-B compare write data |
| cap_val | input | 16 | Capture value, used as TOP in some modes |
| ovf_clr | input | 1 | Software clear for the overflow flag |
| count | output | 16 | Current counter value |
| match_a | output | 1 | Channel-A compare match strobe |
| match_b | output | 1 | Channel-B compare match strobe |
| pwm_a | output | 1 | Channel-A waveform output |
| pwm_b | output | 1 | Channel-B waveform output |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every counting mode is run with compare values placed inside the range, at TOP, and at zero. Placing a compare value at TOP shows whether the fast-ramp set takes priority over the clear. Compare writes arrive in the middle of a period, so an immediate update can be told apart from one deferred to TOP or to zero. Sparse tick patterns separate the advance-on-tick behaviour from free counting. A long free run in mode 0 reaches the 0xFFFF overflow. One phase holds the clear strobe high during overflow events to exercise set-over-clear. Switching to mode 13 mid-count, while ticks and writes continue, shows that the count freezes and no buffered value leaks through.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {K_SINGLE, K_FAST, K_DUAL, K_IDLE} kind_e;
  typedef enum logic [2:0] {TOP_8, TOP_9, TOP_10, TOP_FULL, TOP_CMPA, TOP_CAP} top_src_e;
  typedef enum logic [1:0] {UPD_NOW, UPD_TOP, UPD_BOT} upd_e;
  typedef enum logic [1:0] {EVT_MAX, EVT_TOP, EVT_BOT} evt_e;

  typedef struct packed {
    kind_e    kind;
    top_src_e top_src;
    upd_e     upd;
    evt_e     evt;
  } mode_cfg_t;

  function automatic mode_cfg_t mk_cfg(input kind_e k, input top_src_e s,
                                       input upd_e u, input evt_e e);
    mode_cfg_t c;
    c.kind    = k;
    c.top_src = s;
    c.upd     = u;
    c.evt     = e;
    return c;
  endfunction

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    case (m)
      4'd0:    c = mk_cfg(K_SINGLE, TOP_FULL, UPD_NOW, EVT_MAX);
      4'd1:    c = mk_cfg(K_DUAL,   TOP_8,    UPD_TOP, EVT_BOT);
      4'd2:    c = mk_cfg(K_DUAL,   TOP_9,    UPD_TOP, EVT_BOT);
      4'd3:    c = mk_cfg(K_DUAL,   TOP_10,   UPD_TOP, EVT_BOT);
      4'd4:    c = mk_cfg(K_SINGLE, TOP_CMPA, UPD_NOW, EVT_MAX);
      4'd5:    c = mk_cfg(K_FAST,   TOP_8,    UPD_TOP, EVT_TOP);
      4'd6:    c = mk_cfg(K_FAST,   TOP_9,    UPD_TOP, EVT_TOP);
      4'd7:    c = mk_cfg(K_FAST,   TOP_10,   UPD_TOP, EVT_TOP);
      4'd8:    c = mk_cfg(K_DUAL,   TOP_CAP,  UPD_BOT, EVT_BOT);
      4'd9:    c = mk_cfg(K_DUAL,   TOP_CMPA, UPD_BOT, EVT_BOT);
      4'd10:   c = mk_cfg(K_DUAL,   TOP_CAP,  UPD_TOP, EVT_BOT);
      4'd11:   c = mk_cfg(K_DUAL,   TOP_CMPA, UPD_TOP, EVT_BOT);
      4'd12:   c = mk_cfg(K_SINGLE, TOP_CAP,  UPD_NOW, EVT_MAX);
      4'd14:   c = mk_cfg(K_FAST,   TOP_CAP,  UPD_TOP, EVT_TOP);
      4'd15:   c = mk_cfg(K_FAST,   TOP_CMPA, UPD_TOP, EVT_TOP);
      default: c = mk_cfg(K_IDLE,   TOP_FULL, UPD_BOT, EVT_BOT);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tmr_mode_decode.sv
module tmr_mode_decode
  import tmr_pkg::*;
(
  input  logic [3:0] mode,
  output mode_cfg_t  cfg,
  output logic       run
);

  always_comb begin
    cfg = decode_mode(mode);
    run = (cfg.kind != K_IDLE);
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  kind_e        kind,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt_q,
  output logic         down_q,
  output logic         hit_top,
  output logic         hit_bot,
  output logic         hit_max
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] single_next(input logic [W-1:0] c, input logic [W-1:0] t);
    return (c == t) ? '0 : c + ONE;
  endfunction

  // returns {down, count}
  function automatic logic [W:0] dual_next(input logic [W-1:0] c, input logic [W-1:0] t,
                                           input logic dn);
    logic [W:0] r;
    if (!dn) begin
      if (c < t)        r = {1'b0, c + ONE};
      else if (c == '0) r = {1'b0, c};
      else              r = {1'b1, c - ONE};
    end else begin
      if (c != '0)      r = {1'b1, c - ONE};
      else              r = {1'b0, (t == '0) ? '0 : ONE};
    end
    return r;
  endfunction

  logic [W-1:0] cnt_d;
  logic         down_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (step) begin
      if (kind == K_DUAL) begin
        {down_d, cnt_d} = dual_next(cnt_q, top, down_q);
      end else begin
        cnt_d  = single_next(cnt_q, top);
        down_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign hit_top = (cnt_q == top);
  assign hit_bot = (cnt_q == '0);
  assign hit_max = (cnt_q == '1);

  // R2: no tick, no movement
  p_hold_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));

  // R4: turning at zero moves up to one without repeating zero
  p_bottom_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == K_DUAL && down_q && cnt_q == '0 && top != '0) |=> (cnt_q == ONE && !down_q));

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         upd_imm,
  input  logic         xfer,
  input  logic         step,
  input  kind_e        kind,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic         hit_top,
  output logic [W-1:0] act_q,
  output logic         match_q,
  output logic         pwm_q
);

  logic [W-1:0] shadow_q;
  logic         eq;
  logic         wave_mode;

  assign eq        = (cnt == act_q);
  assign wave_mode = (kind == K_FAST) || (kind == K_DUAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (wr) shadow_q <= wdata;
      if (wr && upd_imm) act_q <= wdata;
      else if (xfer)     act_q <= shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= step && eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else if (!wave_mode) begin
      pwm_q <= 1'b0;
    end else if (step) begin
      if (kind == K_FAST) begin
        if (hit_top) pwm_q <= 1'b1;
        else if (eq) pwm_q <= 1'b0;
      end else if (eq) begin
        pwm_q <= down;
      end
    end
  end

  // R5: immediate-update modes make the write active on the next edge
  p_imm_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && upd_imm) |=> (act_q == $past(wdata)));

  // R6: a strobe only follows a tick
  p_match_needs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> !match_q);

  // R12: non-waveform modes keep the output low
  p_pwm_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_mode |=> !pwm_q);

endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [3:0]   mode,
  input  logic         cmpa_wr,
  input  logic [W-1:0] cmpa_wdata,
  input  logic         cmpb_wr,
  input  logic [W-1:0] cmpb_wdata,
  input  logic [W-1:0] cap_val,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         match_a,
  output logic         match_b,
  output logic         pwm_a,
  output logic         pwm_b,
  output logic         ovf_flag
);

  localparam int NCH = 2;
  localparam logic [W-1:0] FIX8  = W'((1 << 8) - 1);
  localparam logic [W-1:0] FIX9  = W'((1 << 9) - 1);
  localparam logic [W-1:0] FIX10 = W'((1 << 10) - 1);

  function automatic logic [W-1:0] select_top(input top_src_e s, input logic [W-1:0] ca,
                                              input logic [W-1:0] cp);
    logic [W-1:0] t;
    case (s)
      TOP_8:    t = FIX8;
      TOP_9:    t = FIX9;
      TOP_10:   t = FIX10;
      TOP_CMPA: t = ca;
      TOP_CAP:  t = cp;
      default:  t = '1;
    endcase
    return t;
  endfunction

  mode_cfg_t    cfg;
  logic         run;
  logic         step;
  logic [W-1:0] top_val;
  logic [W-1:0] cnt_q;
  logic         down_q;
  logic         hit_top, hit_bot, hit_max;
  logic         upd_imm;
  logic         xfer;
  logic         ovf_event;
  logic         ovf_set;

  logic         ch_wr    [NCH];
  logic [W-1:0] ch_wdata [NCH];
  logic [W-1:0] ch_act   [NCH];
  logic         ch_match [NCH];
  logic         ch_pwm   [NCH];

  tmr_mode_decode u_dec (
    .mode (mode),
    .cfg  (cfg),
    .run  (run)
  );

  assign step    = tick && run;
  assign top_val = select_top(cfg.top_src, ch_act[0], cap_val);

  tmr_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .kind    (cfg.kind),
    .top     (top_val),
    .cnt_q   (cnt_q),
    .down_q  (down_q),
    .hit_top (hit_top),
    .hit_bot (hit_bot),
    .hit_max (hit_max)
  );

  always_comb begin
    upd_imm = (cfg.upd == UPD_NOW);
    case (cfg.upd)
      UPD_TOP: xfer = step && hit_top;
      UPD_BOT: xfer = step && hit_bot;
      default: xfer = 1'b0;
    endcase
    case (cfg.evt)
      EVT_MAX: ovf_event = hit_max;
      EVT_TOP: ovf_event = hit_top;
      default: ovf_event = hit_bot;
    endcase
    ovf_set = step && ovf_event;
  end

  assign ch_wr[0]    = cmpa_wr;
  assign ch_wr[1]    = cmpb_wr;
  assign ch_wdata[0] = cmpa_wdata;
  assign ch_wdata[1] = cmpb_wdata;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_cmp_chan #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ch_wr[i]),
      .wdata   (ch_wdata[i]),
      .upd_imm (upd_imm),
      .xfer    (xfer),
      .step    (step),
      .kind    (cfg.kind),
      .cnt     (cnt_q),
      .down    (down_q),
      .hit_top (hit_top),
      .act_q   (ch_act[i]),
      .match_q (ch_match[i]),
      .pwm_q   (ch_pwm[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_set) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign count   = cnt_q;
  assign match_a = ch_match[0];
  assign match_b = ch_match[1];
  assign pwm_a   = ch_pwm[0];
  assign pwm_b   = ch_pwm[1];

  // R10: an event wins over a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag);

  // R10: a clear without an event drops the flag
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !ovf_set) |=> !ovf_flag);

  // R11: idle mode freezes the count and keeps the strobes low
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(count) && !match_a && !match_b));

endmodule

// File: tb/sim_tmr_wavegen.sv
`timescale 1ns/1ps
module sim_tmr_wavegen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        cmpa_wr = 1'b0;
  logic [15:0] cmpa_wdata = '0;
  logic        cmpb_wr = 1'b0;
  logic [15:0] cmpb_wdata = '0;
  logic [15:0] cap_val = '0;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        match_a, match_b, pwm_a, pwm_b, ovf_flag;

  always #2 clk = ~clk;

  tmr_wavegen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
    .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
    .cap_val(cap_val), .ovf_clr(ovf_clr),
    .count(count), .match_a(match_a), .match_b(match_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .ovf_flag(ovf_flag)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_down, m_acta, m_actb, m_bufa, m_bufb;
  int m_flag, m_mata, m_matb, m_pwma, m_pwmb;

  function automatic bit is_fast(int md);
    return md == 5 || md == 6 || md == 7 || md == 14 || md == 15;
  endfunction
  function automatic bit is_dual(int md);
    return (md >= 1 && md <= 3) || (md >= 8 && md <= 11);
  endfunction
  function automatic int model_top(int md, int ca, int cp);
    if (md == 1 || md == 5) return 255;
    if (md == 2 || md == 6) return 511;
    if (md == 3 || md == 7) return 1023;
    if (md == 4 || md == 9 || md == 11 || md == 15) return ca;
    if (md == 8 || md == 10 || md == 12 || md == 14) return cp;
    return 65535;
  endfunction

  always @(posedge clk) begin
    int md, t, nc, nd, na, nb, ev_at;
    bit tk, upnow, xf;
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_acta = 0; m_actb = 0; m_bufa = 0; m_bufb = 0;
      m_flag = 0; m_mata = 0; m_matb = 0; m_pwma = 0; m_pwmb = 0;
    end else begin
      md = int'(mode);
      tk = tick && (md != 13);
      t = model_top(md, m_acta, int'(cap_val));
      upnow = (md == 0 || md == 4 || md == 12);
      // strobes
      m_mata = (tk && m_cnt == m_acta) ? 1 : 0;
      m_matb = (tk && m_cnt == m_actb) ? 1 : 0;
      // waveforms
      if (!is_fast(md) && !is_dual(md)) begin
        m_pwma = 0; m_pwmb = 0;
      end else if (tk) begin
        if (is_fast(md)) begin
          if (m_cnt == t) begin m_pwma = 1; m_pwmb = 1; end
          else begin
            if (m_cnt == m_acta) m_pwma = 0;
            if (m_cnt == m_actb) m_pwmb = 0;
          end
        end else begin
          if (m_cnt == m_acta) m_pwma = m_down;
          if (m_cnt == m_actb) m_pwmb = m_down;
        end
      end
      // overflow
      if (upnow) ev_at = 65535;
      else if (is_fast(md)) ev_at = t;
      else ev_at = 0;
      if (tk && m_cnt == ev_at) m_flag = 1;
      else if (ovf_clr) m_flag = 0;
      // compare update
      if (md == 8 || md == 9) xf = tk && m_cnt == 0;
      else xf = tk && !upnow && m_cnt == t;
      na = m_acta; nb = m_actb;
      if (cmpa_wr && upnow) na = int'(cmpa_wdata); else if (xf) na = m_bufa;
      if (cmpb_wr && upnow) nb = int'(cmpb_wdata); else if (xf) nb = m_bufb;
      if (cmpa_wr) m_bufa = int'(cmpa_wdata);
      if (cmpb_wr) m_bufb = int'(cmpb_wdata);
      // counter
      nc = m_cnt; nd = m_down;
      if (tk) begin
        if (is_dual(md)) begin
          if (m_down == 0) begin
            if (m_cnt < t) nc = m_cnt + 1;
            else if (m_cnt != 0) begin nc = m_cnt - 1; nd = 1; end
          end else begin
            if (m_cnt > 0) nc = m_cnt - 1;
            else begin nd = 0; nc = (t > 0) ? 1 : 0; end
          end
        end else begin
          nd = 0;
          nc = (m_cnt == t) ? 0 : (m_cnt + 1) % 65536;
        end
      end
      m_cnt = nc; m_down = nd; m_acta = na; m_actb = nb;
    end
  end

  task automatic chk(input string tag, input string name, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  task automatic check_all();
    int md;
    string ctag, mtag, ptag, ftag;
    md = int'(mode);
    if (md == 13) begin ctag = "R11"; mtag = "R11"; ptag = "R11"; end
    else begin
      ctag = is_dual(md) ? "R4/R3" : "R2/R3";
      mtag = "R6/R5";
      ptag = is_fast(md) ? "R7" : (is_dual(md) ? "R8" : "R12");
    end
    ftag = ovf_clr ? "R10" : "R9";
    chk(ctag, "count",   int'(count),   m_cnt);
    chk(mtag, "match_a", int'(match_a), m_mata);
    chk(mtag, "match_b", int'(match_b), m_matb);
    chk(ptag, "pwm_a",   int'(pwm_a),   m_pwma);
    chk(ptag, "pwm_b",   int'(pwm_b),   m_pwmb);
    chk(ftag, "ovf_flag", int'(ovf_flag), m_flag);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; ovf_clr = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  task automatic wr_ab(input int a, input int b);
    cmpa_wr = 1'b1; cmpa_wdata = 16'(a);
    cmpb_wr = 1'b1; cmpb_wdata = 16'(b);
    tick = 1'b1;
    cyc();
    cmpa_wr = 1'b0; cmpb_wr = 1'b0;
  endtask

  task automatic wr_a(input int a);
    cmpa_wr = 1'b1; cmpa_wdata = 16'(a); tick = 1'b1;
    cyc();
    cmpa_wr = 1'b0;
  endtask

  // tp: tick every tp cycles (1 = every cycle); cp: clear every cp cycles (0 = never)
  task automatic run(input int n, input int tp, input int cp);
    for (int i = 0; i < n; i++) begin
      tick = (i % tp) == 0;
      ovf_clr = (cp != 0) && ((i % cp) == 0);
      cyc();
    end
    tick = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic phase(input int md, input int cap, input int a, input int b);
    mode = 4'(md); cap_val = 16'(cap);
    do_reset();
    wr_ab(a, b);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1", "count",    int'(count), 0);
    chk("R1", "match_a",  int'(match_a), 0);
    chk("R1", "match_b",  int'(match_b), 0);
    chk("R1", "pwm_a",    int'(pwm_a), 0);
    chk("R1", "pwm_b",    int'(pwm_b), 0);
    chk("R1", "ovf_flag", int'(ovf_flag), 0);

    // mode 0: free run through 0xFFFF (R2, R9, R12), then clear (R10)
    phase(0, 0, 5, 9);
    run(65600, 1, 0);
    run(20, 1, 1);

    // mode 4: compare-A ceiling, sparse ticks (R3, R2)
    phase(4, 0, 20, 7);
    run(300, 2, 50);
    // mode 12: capture ceiling
    phase(12, 30, 12, 40);
    run(200, 1, 37);

    // fast ramps (R7), buffered writes at TOP (R5)
    phase(5, 0, 64, 255);
    run(600, 1, 0);
    wr_a(16);
    run(600, 1, 300);
    phase(6, 0, 256, 0);
    run(1100, 1, 0);
    phase(7, 0, 512, 1023);
    run(2100, 1, 0);
    phase(14, 45, 45, 0);
    run(400, 1, 60);
    phase(15, 0, 9, 4);
    run(300, 2, 0);

    // dual ramps (R4, R8)
    phase(1, 0, 128, 0);
    run(1100, 1, 0);
    wr_a(32);
    run(600, 1, 200);
    phase(2, 0, 100, 511);
    run(1100, 1, 0);
    phase(3, 0, 700, 1);
    run(2100, 1, 0);
    phase(8, 50, 10, 40);
    run(300, 1, 0);
    wr_a(25);
    run(300, 3, 0);
    phase(9, 0, 40, 15);
    run(400, 1, 0);
    wr_a(30);
    run(300, 1, 0);
    phase(10, 60, 20, 60);
    run(400, 1, 90);
    phase(11, 0, 33, 10);
    run(400, 1, 0);

    // R10: clear held high while events keep firing
    phase(15, 0, 3, 1);
    run(200, 1, 1);

    // R11: switch to idle mid-count; ticks and writes must have no effect
    phase(15, 0, 11, 5);
    run(7, 1, 0);
    mode = 4'd13;
    run(50, 1, 0);
    wr_ab(2, 2);
    run(50, 1, 0);
    mode = 4'd15;
    run(100, 1, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule